// File: doc/BRIEF.md
# Double-and-Add Scalar Multiplication Sequencer

This block works out Q = nP for a KBITS-wide scalar n and a base point P. It does no field arithmetic of its own. It walks the scalar from its most significant bit down to bit 0. For each bit it sends a point-doubling command and, when the bit is one, a point-addition command to an external point unit that works in homogeneous projective coordinates (X, Y, Z). Because the unit works in projective form, no field inversion is ever requested.

Q and a captured copy of P sit in coordinate registers. Q is always the first operand of a command, and the captured P is always the second. When the unit reports that a command has finished, the coordinates it returns are written into Q.

The accumulator is not started from the identity. It is seeded from the top scalar bit. A flag marks when Q is the point at infinity, and while the flag is set the sequencer settles each step itself, so the unit never receives the identity point. Conversion back to affine form, scalar recoding and side-channel hardening belong to other blocks.

Top module: `scalar_mult_seq`

## Requirements
- R1: A start pulse while idle captures the scalar and the three P coordinates. Later changes on those inputs have no effect on the running job or on its result.
- R2: On capture, Q is loaded with P and qInf is cleared when scalar bit KBITS-1 is 1. When that bit is 0, qInf is set.
- R3: For each bit i from KBITS-2 down to 0, a doubling (cmdOp = 0) of Q is issued first, unless qInf is set.
- R4: After the doubling, if bit i is 1, an addition (cmdOp = 1) is issued. The Q outputs are operand A and opBX/opBY/opBZ (the captured P) are operand B.
- R5: Each command is a single-cycle cmdValid. The sequencer then waits for a single-cycle opDone and loads resX/resY/resZ into Q on that cycle.
- R6: After bit 0 has been handled, done pulses for exactly one cycle with busy high. The Q outputs and qInf then hold the result, and busy falls on the next cycle.
- R7: While qInf is set, a doubling is skipped and Q stays at infinity. An addition instead copies P into Q and clears qInf. No command is ever issued while qInf is set.
- R8: A zero scalar issues no command and still ends with a done pulse and qInf set.
- R9: A start pulse while busy is ignored, and the running job ends with its own result.
- R10: Operand B stays constant for as long as busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a job when idle |
| scalar | input | KBITS | Scalar n |
| pX | input | CW | Base point X |
| pY | input | CW | Base point Y |
| pZ | input | CW | Base point Z |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| qX | output | CW | Accumulator X, also operand A |
| qY | output | CW | Accumulator Y, also operand A |
| qZ | output | CW | Accumulator Z, also operand A |
| qInf | output | 1 | Accumulator is the point at infinity |
| cmdValid | output | 1 | One-cycle command strobe |
| cmdOp | output | 1 | 0 = double, 1 = add |
| opBX | output | CW | Operand B X (captured P) |
| opBY | output | CW | Operand B Y (captured P) |
| opBZ | output | CW | Operand B Z (captured P) |
| opDone | input | 1 | One-cycle completion from the point unit |
| resX | input | CW | Result X from the point unit |
| resY | input | CW | Result Y from the point unit |
| resZ | input | CW | Result Z from the point unit |

## Verification
The bench targets the following corner cases.

- **Leading zero bits in the scalar.** A design that doubled the identity would send commands while qInf is set. One that mishandled the first set bit would add to a stale Q instead of copying P.
- **Scalars of zero, one, a lone top bit and all ones.** These expose an off-by-one in the bit count, a skipped final addition, or a missing done pulse on a job that never issues a command.
- **Changing inputs and a second start mid-job.** These catch a design that reads P or the scalar live instead of using the captured copy.
- **Point-unit latencies that vary from one to three cycles.** These catch a design that loads Q before opDone or that holds cmdValid for more than one cycle.

// File: rtl/scalar_mult_pkg.sv
package scalar_mult_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DBL,
    S_WDBL,
    S_ADD,
    S_WADD,
    S_NEXT,
    S_FIN
  } seqStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture scalar and P, seed Q
    logic takeRes;  // Q := point unit result
    logic copyP;    // Q := P, leave infinity
    logic shift;    // advance to next scalar bit
  } ctlStrobesT;

endpackage

// File: rtl/scalar_mult_dp.sv
module scalar_mult_dp
  import scalar_mult_pkg::*;
#(
  parameter int KBITS = 8,
  parameter int CW    = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobesT           ctl,
  input  logic [KBITS-1:0]     scalarIn,
  input  logic [2:0][CW-1:0]   pIn,
  input  logic [2:0][CW-1:0]   resIn,
  output logic [2:0][CW-1:0]   qOut,
  output logic [2:0][CW-1:0]   pOut,
  output logic                 qInf,
  output logic                 curBit
);

  localparam int NCOORD = 3;

  logic [KBITS-1:0]        scanReg;
  logic [NCOORD-1:0][CW-1:0] pReg;
  logic [NCOORD-1:0][CW-1:0] qReg;
  logic                    infReg;

  // one register slice per coordinate
  for (genvar c = 0; c < NCOORD; c++) begin : g_coord
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pReg[c] <= '0;
        qReg[c] <= '0;
      end else begin
        if (ctl.load) begin
          pReg[c] <= pIn[c];
          qReg[c] <= pIn[c];
        end else if (ctl.takeRes) begin
          qReg[c] <= resIn[c];
        end else if (ctl.copyP) begin
          qReg[c] <= pReg[c];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scanReg <= '0;
      infReg  <= 1'b1;
    end else begin
      if (ctl.load) begin
        scanReg <= scalarIn << 1;
        infReg  <= ~scalarIn[KBITS-1];
      end else begin
        if (ctl.shift) scanReg <= scanReg << 1;
        if (ctl.copyP) infReg  <= 1'b0;
      end
    end
  end

  assign curBit = scanReg[KBITS-1];
  assign qOut   = qReg;
  assign pOut   = pReg;
  assign qInf   = infReg;

  // R7: result from the unit never arrives while at infinity
  p_no_result_at_inf_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.takeRes |-> !infReg);

endmodule

// File: rtl/scalar_mult_ctrl.sv
module scalar_mult_ctrl
  import scalar_mult_pkg::*;
#(
  parameter int KBITS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       opDone,
  input  logic       curBit,
  input  logic       qInf,
  output ctlStrobesT ctl,
  output logic       cmdValid,
  output logic       cmdOp,
  output logic       busy,
  output logic       done
);

  localparam int CNTW = $clog2(KBITS) + 1;

  seqStateT        state, nextState;
  logic [CNTW-1:0] bitsLeft;

  always_comb begin
    nextState = state;
    ctl       = '0;
    cmdValid  = 1'b0;
    cmdOp     = 1'b0;
    done      = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          ctl.load  = 1'b1;
          nextState = (KBITS == 1) ? S_FIN : S_DBL;
        end
      end
      S_DBL: begin
        if (qInf) begin
          nextState = S_ADD;
        end else begin
          cmdValid  = 1'b1;
          nextState = S_WDBL;
        end
      end
      S_WDBL: begin
        if (opDone) begin
          ctl.takeRes = 1'b1;
          nextState   = S_ADD;
        end
      end
      S_ADD: begin
        if (!curBit) begin
          nextState = S_NEXT;
        end else if (qInf) begin
          ctl.copyP = 1'b1;
          nextState = S_NEXT;
        end else begin
          cmdValid  = 1'b1;
          cmdOp     = 1'b1;
          nextState = S_WADD;
        end
      end
      S_WADD: begin
        if (opDone) begin
          ctl.takeRes = 1'b1;
          nextState   = S_NEXT;
        end
      end
      S_NEXT: begin
        ctl.shift = 1'b1;
        nextState = (bitsLeft == CNTW'(1)) ? S_FIN : S_DBL;
      end
      S_FIN: begin
        done      = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      bitsLeft <= '0;
    end else begin
      state <= nextState;
      if (ctl.load)       bitsLeft <= CNTW'(KBITS - 1);
      else if (ctl.shift) bitsLeft <= bitsLeft - CNTW'(1);
    end
  end

  assign busy = (state != S_IDLE);

  // R5: a command strobe lasts a single cycle
  p_cmd_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  // R6: done is a single-cycle pulse and the block is idle afterwards
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  // R9: a start while busy does not restart the bit count
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !ctl.shift) |=> $stable(bitsLeft));

endmodule

// File: rtl/scalar_mult_seq.sv
module scalar_mult_seq
  import scalar_mult_pkg::*;
#(
  parameter int KBITS = 8,
  parameter int CW    = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [KBITS-1:0] scalar,
  input  logic [CW-1:0]    pX,
  input  logic [CW-1:0]    pY,
  input  logic [CW-1:0]    pZ,
  output logic             busy,
  output logic             done,
  output logic [CW-1:0]    qX,
  output logic [CW-1:0]    qY,
  output logic [CW-1:0]    qZ,
  output logic             qInf,
  output logic             cmdValid,
  output logic             cmdOp,
  output logic [CW-1:0]    opBX,
  output logic [CW-1:0]    opBY,
  output logic [CW-1:0]    opBZ,
  input  logic             opDone,
  input  logic [CW-1:0]    resX,
  input  logic [CW-1:0]    resY,
  input  logic [CW-1:0]    resZ
);

  ctlStrobesT         ctl;
  logic               curBit;
  logic [2:0][CW-1:0] qVec, pVec;

  scalar_mult_ctrl #(.KBITS(KBITS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .opDone   (opDone),
    .curBit   (curBit),
    .qInf     (qInf),
    .ctl      (ctl),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .busy     (busy),
    .done     (done)
  );

  scalar_mult_dp #(.KBITS(KBITS), .CW(CW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .scalarIn (scalar),
    .pIn      ({pZ, pY, pX}),
    .resIn    ({resZ, resY, resX}),
    .qOut     (qVec),
    .pOut     (pVec),
    .qInf     (qInf),
    .curBit   (curBit)
  );

  assign qX   = qVec[0];
  assign qY   = qVec[1];
  assign qZ   = qVec[2];
  assign opBX = pVec[0];
  assign opBY = pVec[1];
  assign opBZ = pVec[2];

  // R7: the identity point is never handed to the point unit
  p_no_cmd_at_inf_r7: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> !qInf);

  // R10: operand B holds still for the whole job
  p_base_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busy) && busy) |-> $stable({opBX, opBY, opBZ}));

  // R6: done only appears while busy
  p_done_in_job_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

endmodule

// File: tb/scalar_mult_seq_bench.sv
module scalar_mult_seq_bench;

  localparam int KBITS = 8;
  localparam int CW    = 16;
  localparam int WDOG  = 150000;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [KBITS-1:0] scalar = '0;
  logic [CW-1:0]    pX = '0, pY = '0, pZ = '0;
  logic             busy, done, qInf, cmdValid, cmdOp;
  logic [CW-1:0]    qX, qY, qZ, opBX, opBY, opBZ;
  logic             opDone = 1'b0;
  logic [CW-1:0]    resX = '0, resY = '0, resZ = '0;

  always #10 clk = ~clk;  // 50 MHz

  scalar_mult_seq #(.KBITS(KBITS), .CW(CW)) u_scalar_mult_seq (
    .clk(clk), .rstN(rstN), .start(start), .scalar(scalar),
    .pX(pX), .pY(pY), .pZ(pZ), .busy(busy), .done(done),
    .qX(qX), .qY(qY), .qZ(qZ), .qInf(qInf),
    .cmdValid(cmdValid), .cmdOp(cmdOp),
    .opBX(opBX), .opBY(opBY), .opBZ(opBZ),
    .opDone(opDone), .resX(resX), .resY(resY), .resZ(resZ)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit timedOut = 0;

  // expected command stream: {op, ax, ay, az}
  logic [3*CW:0] expCmds[$];
  logic [CW-1:0] refPX, refPY, refPZ;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // toy point arithmetic shared by the fake unit and the model
  function automatic logic [3*CW-1:0] toyDbl(input logic [CW-1:0] x, y, z);
    logic [CW-1:0] nx, ny, nz;
    nx = x * 3 + 1;
    ny = y + z;
    nz = z * 2 + 1;
    return {nx, ny, nz};
  endfunction

  function automatic logic [3*CW-1:0] toyAdd(input logic [CW-1:0] x, y, z,
                                             input logic [CW-1:0] bx, by, bz);
    logic [CW-1:0] nx, ny, nz;
    nx = x + bx;
    ny = y ^ by;
    nz = z + bz + 1;
    return {nx, ny, nz};
  endfunction

  // fake point unit with rotating latency, plus per-clock stream compare
  int pend = 0;
  int latSel = 0;
  logic [3*CW-1:0] pendRes;

  always @(negedge clk) begin
    cycles++;
    opDone = 1'b0;
    if (cycles > WDOG && !timedOut) begin
      timedOut = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<%0d", cycles, WDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
    if (rstN) begin
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          opDone = 1'b1;
          {resX, resY, resZ} = pendRes;
        end
      end else if (cmdValid) begin
        check(!qInf, "R7", "command while at infinity", qInf, 0);
        if (expCmds.size() == 0) begin
          check(0, "R3", "unexpected command", cmdOp, 0);
        end else begin
          logic [3*CW:0] e;
          e = expCmds.pop_front();
          check({cmdOp, qX, qY, qZ} == e, cmdOp ? "R4" : "R3",
                "command op/operand A", {cmdOp, qX, qY, qZ}, e);
          check({opBX, opBY, opBZ} == {refPX, refPY, refPZ}, "R10",
                "operand B", {opBX, opBY, opBZ}, {refPX, refPY, refPZ});
        end
        pendRes = cmdOp ? toyAdd(qX, qY, qZ, opBX, opBY, opBZ)
                        : toyDbl(qX, qY, qZ);
        pend = 1 + (latSel % 3);
        latSel++;
      end
    end
  end

  task automatic runCase(input logic [KBITS-1:0] n,
                         input logic [CW-1:0] px, py, pz, input bit poke);
    logic [CW-1:0] mx, my, mz;
    bit inf;
    int wait1;
    // reference model of the scan
    expCmds.delete();
    refPX = px; refPY = py; refPZ = pz;
    inf = !n[KBITS-1];
    mx = px; my = py; mz = pz;
    for (int i = KBITS - 2; i >= 0; i--) begin
      if (!inf) begin
        expCmds.push_back({1'b0, mx, my, mz});
        {mx, my, mz} = toyDbl(mx, my, mz);
      end
      if (n[i]) begin
        if (inf) begin
          mx = px; my = py; mz = pz; inf = 0;
        end else begin
          expCmds.push_back({1'b1, mx, my, mz});
          {mx, my, mz} = toyAdd(mx, my, mz, px, py, pz);
        end
      end
    end
    @(negedge clk);
    start = 1'b1; scalar = n; pX = px; pY = py; pZ = pz;
    @(negedge clk);
    start = 1'b0; scalar = ~n; pX = ~px; pY = py + 7; pZ = ~pz;  // R1
    check(busy, "R6", "busy after start", busy, 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1; scalar = ~n;  // R9
      @(negedge clk);
      start = 1'b0;
    end
    wait1 = 0;
    while (!done && !timedOut) begin
      @(negedge clk);
      wait1++;
    end
    check(busy, "R6", "busy during done", busy, 1);
    check(expCmds.size() == 0, inf ? "R8" : "R3", "commands left over",
          expCmds.size(), 0);
    check(qInf == inf, inf ? "R8" : "R2", "infinity flag", qInf, inf);
    if (!inf)
      check({qX, qY, qZ} == {mx, my, mz}, poke ? "R9" : "R1",
            "result point", {qX, qY, qZ}, {mx, my, mz});
    @(negedge clk);
    check(!done && !busy, "R6", "done/busy after pulse", {done, busy}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !cmdValid && qInf, "R6", "reset state",
          {busy, done, cmdValid, qInf}, 4'b0001);
    rstN = 1'b1;
    @(negedge clk);
    runCase(8'hB5, 16'h1234, 16'h5678, 16'h0001, 0);  // R2 R3 R4 R5
    runCase(8'h00, 16'h1111, 16'h2222, 16'h3333, 0);  // R8
    runCase(8'h01, 16'hAAAA, 16'hBBBB, 16'hCCCC, 0);  // R7 copy at bit 0
    runCase(8'h80, 16'h0F0F, 16'hF0F0, 16'h0005, 0);  // doubles only
    runCase(8'hFF, 16'h0002, 16'h0003, 16'h0004, 0);  // all additions
    runCase(8'h2C, 16'h7777, 16'h0101, 16'h0010, 0);  // R7 leading zeros
    runCase(8'hC3, 16'h4321, 16'h8765, 16'h0009, 1);  // R9 start while busy
    for (int k = 0; k < 6; k++)
      runCase(KBITS'(k * 37 + 91), CW'(k * 4099 + 3), CW'(k * 257 + 11),
              CW'(k + 1), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule